// File: doc/BRIEF.md
# Micro-TLB with Last-Hit Shortcut

This block is a small fully associative translation cache that maps a virtual page number to a physical frame number. It keeps a pointer to the entry that served the most recent successful translation. Each new lookup first tries that one entry on its own. The full set of tag comparators is switched on only when that single check fails. This saves comparator activity on the common case of repeated accesses to the same page.

A refill from the next translation level writes a victim slot. The victim is the lowest-numbered empty slot if one exists. Otherwise it is the least recently used slot, tracked by a square usage matrix. A matrix write happens only when the touched slot is not already the most recent one, so a run of hits to the same page leaves the matrix bits untouched.

A flush drops every mapping and the shortcut pointer. An output counter reports how many lookups fell back to the full compare.

Top module: `utlb_top`

## Requirements
- R1: After reset every slot is empty, `busy`, `respValid` and `fullCmpCount` are 0, and no response appears until a lookup is accepted.
- R2: A mapping written by refill can sit in any slot and is found by a lookup of its page number, which returns the frame number written with it.
- R3: When the lookup page matches the slot named by the shortcut pointer, the response (`respValid`=1, `respHit`=1) appears at the clock edge that accepts the lookup. The `fullCmpCount` output stays unchanged, and at most one slot comparator is enabled in that cycle.
- R4: When the shortcut check fails, `busy` is high for exactly one cycle and the response appears one edge later, two edges after acceptance. A hit on this path repoints the shortcut at the matching slot.
- R5: A lookup that matches no valid slot returns `respValid`=1 with `respHit`=0, `respMiss`=1 and `respPfn`=0.
- R6: A refill goes to the lowest-numbered empty slot while one exists, and that slot becomes valid.
- R7: When all slots are valid, a refill replaces the least recently used mapping. A successful lookup or a refill makes its slot the most recently used.
- R8: Touching the slot that is already most recently used writes no usage-matrix bit, and the replacement order is unchanged.
- R9: After a refill the shortcut points at the refilled slot, so the next lookup of that page completes on the short path.
- R10: `flush` empties every slot and clears the shortcut pointer. Afterwards every page misses through the full-compare path.
- R11: `fullCmpCount` goes up by one for every lookup that takes the full-compare path, whether it hits or misses, and does not change otherwise.
- R12: A lookup is not accepted while `busy` is high, or in a cycle where `refillValid` or `flush` is high. A lookup that is not accepted produces no response. A refill is taken only when `busy` is low, and `flush` takes priority over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVpn | input | 20 | Virtual page number to translate |
| busy | output | 1 | Full compare in progress; new requests are not taken |
| respValid | output | 1 | One-cycle response strobe |
| respHit | output | 1 | Response found a mapping |
| respMiss | output | 1 | Response found no mapping |
| respPfn | output | 20 | Translated frame number, 0 on a miss |
| refillValid | input | 1 | Refill write strobe |
| refillVpn | input | 20 | Page number of the new mapping |
| refillPfn | input | 20 | Frame number of the new mapping |
| flush | input | 1 | Drop all mappings and the shortcut |
| fullCmpCount | output | 16 | Number of lookups that used the full compare |

## Verification
The bench fills all eight slots, then steers the usage order with lookups and checks which mapping each later refill evicts. A victim picker that ignores recency would evict the wrong page, and a hit that did not refresh recency would evict a page that was just used. It repeats hits on the most recent slot before a refill to show that the order survives gated updates. It measures the latency of every response to tell the shortcut path from the fallback path. A pointer that failed to follow refills or fallback hits would show up as two-cycle responses where one cycle is expected. It also presents a lookup together with a refill to show the lookup is dropped, and checks after a flush that stale pages miss and fresh refills fill empty slots first.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  // strobes from control to datapath for the current cycle
  typedef struct packed {
    logic histChk;   // compare only the shortcut slot
    logic fullCmp;   // compare every slot
    logic refillWr;  // write victim slot
    logic touchEn;   // update recency for touchIdx
    logic flushAll;  // invalidate every slot
  } utlbStrobe_t;

  typedef enum logic {ST_IDLE, ST_FULL} utlbState_e;

endpackage

// File: rtl/utlb_lru.sv
module utlb_lru #(
  parameter int ENTRIES = 8,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          touchEn,
  input  logic [IW-1:0] touchIdx,
  output logic [IW-1:0] lruIdx
);

  logic [ENTRIES-1:0] mtx [ENTRIES];
  logic [ENTRIES-1:0] zeroRow;
  logic [ENTRIES-1:0] fullRow;
  logic [ENTRIES*ENTRIES-1:0] mtxFlat;
  logic writeEn;

  always_comb begin
    for (int r = 0; r < ENTRIES; r++) begin
      zeroRow[r] = (mtx[r] == '0);
      fullRow[r] = ((mtx[r] | (ENTRIES'(1) << r)) == '1);
      mtxFlat[r*ENTRIES +: ENTRIES] = mtx[r];
    end
  end

  // gate: no write when the touched slot already leads the order
  assign writeEn = touchEn && !fullRow[touchIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ENTRIES; r++)
        for (int c = 0; c < ENTRIES; c++)
          mtx[r][c] <= (c < r);
    end else if (writeEn) begin
      for (int r = 0; r < ENTRIES; r++)
        for (int c = 0; c < ENTRIES; c++)
          if (r == int'(touchIdx)) mtx[r][c] <= (c != r);
          else if (c == int'(touchIdx)) mtx[r][c] <= 1'b0;
    end
  end

  always_comb begin
    lruIdx = '0;
    for (int r = ENTRIES - 1; r >= 0; r--)
      if (zeroRow[r]) lruIdx = IW'(r);
  end

  AST_SINGLE_LRU: assert property (@(posedge clk) disable iff (!rstN)
    $countones(zeroRow) == 1);                                        // R7
  AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (!rstN)
    touchEn |=> fullRow[$past(touchIdx)]);                            // R7
  AST_LRU_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (touchEn && fullRow[touchIdx]) |=> $stable(mtxFlat));             // R8

endmodule

// File: rtl/utlb_dp.sv
module utlb_dp
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  utlbStrobe_t      strobe,
  input  logic [IW-1:0]    histIdx,
  input  logic [IW-1:0]    touchIdx,
  input  logic [VPN_W-1:0] cmpVpn,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PFN_W-1:0] refillPfn,
  output logic             match,
  output logic [IW-1:0]    matchIdx,
  output logic [PFN_W-1:0] matchPfn,
  output logic [IW-1:0]    victimIdx
);

  logic [VPN_W-1:0]   tagMem [ENTRIES];
  logic [PFN_W-1:0]   pfnMem [ENTRIES];
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] cmpEn;
  logic [ENTRIES-1:0] eqVec;
  logic [IW-1:0]      lruIdx;
  logic               anyFree;
  logic [IW-1:0]      freeIdx;

  // per-slot comparators, enabled one at a time on the short path
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign cmpEn[g] = strobe.fullCmp || (strobe.histChk && histIdx == IW'(g));
    assign eqVec[g] = cmpEn[g] && validVec[g] && (tagMem[g] == cmpVpn);
  end

  always_comb begin
    matchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (eqVec[i]) matchIdx = IW'(i);
  end
  assign match    = |eqVec;
  assign matchPfn = pfnMem[matchIdx];

  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!validVec[i]) freeIdx = IW'(i);
  end
  assign anyFree   = ~&validVec;
  assign victimIdx = anyFree ? freeIdx : lruIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (strobe.flushAll) begin
      validVec <= '0;
    end else if (strobe.refillWr) begin
      validVec[victimIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.refillWr && !strobe.flushAll) begin
      tagMem[victimIdx] <= refillVpn;
      pfnMem[victimIdx] <= refillPfn;
    end
  end

  utlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk     (clk),
    .rstN    (rstN),
    .touchEn (strobe.touchEn),
    .touchIdx(touchIdx),
    .lruIdx  (lruIdx)
  );

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> validVec == '0);                              // R10
  AST_REFILL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.refillWr && !strobe.flushAll) |=> validVec[$past(victimIdx)]); // R6
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.refillWr && anyFree) |-> !validVec[victimIdx]);           // R6
  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fullCmp |-> $countones(eqVec) <= 1);                       // R2

endmodule

// File: rtl/utlb_ctrl.sv
module utlb_ctrl
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int CNT_W = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic             refillValid,
  input  logic             flush,
  input  logic             match,
  input  logic [IW-1:0]    matchIdx,
  input  logic [PFN_W-1:0] matchPfn,
  input  logic [IW-1:0]    victimIdx,
  output utlbStrobe_t      strobe,
  output logic [IW-1:0]    histIdx,
  output logic [IW-1:0]    touchIdx,
  output logic [VPN_W-1:0] cmpVpn,
  output logic             busy,
  output logic             respValid,
  output logic             respHit,
  output logic [PFN_W-1:0] respPfn,
  output logic [CNT_W-1:0] fullCmpCount
);

  utlbState_e       state;
  logic             histValid;
  logic [VPN_W-1:0] heldVpn;
  logic             accept;
  logic             doRefill;

  assign accept   = (state == ST_IDLE) && lookupValid && !refillValid && !flush;
  assign doRefill = (state == ST_IDLE) && refillValid && !flush;

  always_comb begin
    strobe.histChk  = accept && histValid;
    strobe.fullCmp  = (state == ST_FULL) && !flush;
    strobe.refillWr = doRefill;
    strobe.flushAll = flush;
    strobe.touchEn  = doRefill || ((strobe.histChk || strobe.fullCmp) && match);
  end

  assign touchIdx = doRefill ? victimIdx : matchIdx;
  assign cmpVpn   = (state == ST_FULL) ? heldVpn : lookupVpn;
  assign busy     = (state == ST_FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      histValid    <= 1'b0;
      histIdx      <= '0;
      heldVpn      <= '0;
      respValid    <= 1'b0;
      respHit      <= 1'b0;
      respPfn      <= '0;
      fullCmpCount <= '0;
    end else if (flush) begin
      state     <= ST_IDLE;
      histValid <= 1'b0;
      respValid <= 1'b0;
    end else begin
      respValid <= 1'b0;
      if (accept) begin
        heldVpn <= lookupVpn;
        if (strobe.histChk && match) begin
          respValid <= 1'b1;
          respHit   <= 1'b1;
          respPfn   <= matchPfn;
        end else begin
          state <= ST_FULL;
        end
      end
      if (state == ST_FULL) begin
        state        <= ST_IDLE;
        respValid    <= 1'b1;
        respHit      <= match;
        respPfn      <= match ? matchPfn : '0;
        fullCmpCount <= fullCmpCount + CNT_W'(1);
        if (match) begin
          histIdx   <= matchIdx;
          histValid <= 1'b1;
        end
      end
      if (doRefill) begin
        histIdx   <= victimIdx;
        histValid <= 1'b1;
      end
    end
  end

  AST_SHORT_PATH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.histChk && match) |=> (respValid && respHit && $stable(fullCmpCount))); // R3
  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);                                                  // R4
  AST_FALLBACK_RESP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fullCmp |=> (respValid && fullCmpCount == $past(fullCmpCount) + CNT_W'(1))); // R11
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> respPfn == '0);                       // R5
  AST_REFILL_HIST: assert property (@(posedge clk) disable iff (!rstN)
    doRefill |=> (histValid && histIdx == $past(victimIdx)));         // R9
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy || flush || refillValid) |-> !accept);                      // R12

endmodule

// File: rtl/utlb_top.sv
module utlb_top
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             busy,
  output logic             respValid,
  output logic             respHit,
  output logic             respMiss,
  output logic [PFN_W-1:0] respPfn,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PFN_W-1:0] refillPfn,
  input  logic             flush,
  output logic [CNT_W-1:0] fullCmpCount
);

  localparam int IW = $clog2(ENTRIES);

  utlbStrobe_t      strobe;
  logic [IW-1:0]    histIdx;
  logic [IW-1:0]    touchIdx;
  logic [VPN_W-1:0] cmpVpn;
  logic             match;
  logic [IW-1:0]    matchIdx;
  logic [PFN_W-1:0] matchPfn;
  logic [IW-1:0]    victimIdx;

  utlb_ctrl #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .refillValid(refillValid), .flush(flush),
    .match(match), .matchIdx(matchIdx), .matchPfn(matchPfn), .victimIdx(victimIdx),
    .strobe(strobe), .histIdx(histIdx), .touchIdx(touchIdx), .cmpVpn(cmpVpn),
    .busy(busy), .respValid(respValid), .respHit(respHit), .respPfn(respPfn),
    .fullCmpCount(fullCmpCount)
  );

  utlb_dp #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .histIdx(histIdx), .touchIdx(touchIdx), .cmpVpn(cmpVpn),
    .refillVpn(refillVpn), .refillPfn(refillPfn),
    .match(match), .matchIdx(matchIdx), .matchPfn(matchPfn), .victimIdx(victimIdx)
  );

  assign respMiss = respValid && !respHit;

endmodule

// File: tb/utlb_top_tb.sv
module utlb_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [19:0] lookupVpn = '0;
  logic        busy, respValid, respHit, respMiss;
  logic [19:0] respPfn;
  logic        refillValid = 1'b0;
  logic [19:0] refillVpn = '0;
  logic [19:0] refillPfn = '0;
  logic        flush = 1'b0;
  logic [15:0] fullCmpCount;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int expCount = 0;
  logic        hValid = 1'b0;
  logic [19:0] hVpn = '0;

  typedef struct {
    logic        hit;
    logic [19:0] pfn;
    int          lat;
    int          issue;
    string       tag;
  } expItem_t;
  expItem_t sbq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  utlb_top u_dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .busy(busy), .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respPfn(respPfn), .refillValid(refillValid), .refillVpn(refillVpn),
    .refillPfn(refillPfn), .flush(flush), .fullCmpCount(fullCmpCount)
  );

  function automatic logic [19:0] pfnOf(logic [19:0] v);
    return v ^ 20'h5A5A5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected item on each response
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R12 unexpected response", 1, 0);
      end else begin
        expItem_t e;
        e = sbq.pop_front();
        chk(respHit == e.hit && respMiss == !e.hit, {e.tag, " hit"}, int'(respHit), int'(e.hit));
        chk(respPfn == e.pfn, {e.tag, " pfn"}, int'(respPfn), int'(e.pfn));
        chk(cyc - e.issue == e.lat, {e.tag, " latency"}, cyc - e.issue, e.lat);
      end
    end
  end

  task automatic doLookup(input logic [19:0] v, input logic expHit, input string tag);
    expItem_t e;
    e.hit = expHit;
    e.pfn = expHit ? pfnOf(v) : '0;
    e.lat = (hValid && hVpn == v) ? 1 : 2;
    e.tag = tag;
    if (e.lat == 2) begin
      expCount++;
      if (expHit) begin hVpn = v; hValid = 1'b1; end
    end
    @(negedge clk);
    lookupValid = 1'b1;
    lookupVpn = v;
    e.issue = cyc;
    sbq.push_back(e);
    @(negedge clk);
    lookupValid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic doRefill(input logic [19:0] v);
    @(negedge clk);
    refillValid = 1'b1;
    refillVpn = v;
    refillPfn = pfnOf(v);
    @(negedge clk);
    refillValid = 1'b0;
    hVpn = v;
    hValid = 1'b1;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    hValid = 1'b0;
  endtask

  task automatic chkCount(input string tag);
    @(negedge clk);
    chk(fullCmpCount == 16'(expCount), tag, int'(fullCmpCount), expCount);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !respValid, "R1 idle outputs", int'({busy, respValid}), 0);
    chk(fullCmpCount == 0, "R1 counter", int'(fullCmpCount), 0);

    doLookup(20'h00777, 1'b0, "R5 empty miss");
    chkCount("R11 count after miss");

    // R6: fill slots 0..7 in order
    for (int i = 0; i < 8; i++) doRefill(20'h10000 + 20'(i));
    doLookup(20'h10007, 1'b1, "R9 refilled page short path");
    doLookup(20'h10003, 1'b1, "R2 R4 fallback hit");
    doLookup(20'h10003, 1'b1, "R3 repeated page short path");
    chkCount("R11 count after fallback");

    // recency: order is 0,1,2,4,5,6,7,3 ; touch 0
    doLookup(20'h10000, 1'b1, "R4 fallback hit on oldest");
    for (int i = 0; i < 3; i++) doLookup(20'h10000, 1'b1, "R8 hits on most recent");
    doRefill(20'h20000);
    doLookup(20'h10001, 1'b0, "R7 lru page evicted");
    doLookup(20'h10000, 1'b1, "R7 recently used page kept");
    doLookup(20'h20000, 1'b1, "R2 new page present");
    for (int i = 0; i < 2; i++) doLookup(20'h20000, 1'b1, "R8 gated repeats");
    doRefill(20'h30000);
    doLookup(20'h10002, 1'b0, "R8 order kept next victim");
    doLookup(20'h30000, 1'b1, "R9 shortcut after refill");
    doLookup(20'h10004, 1'b1, "R7 younger page kept");
    chkCount("R11 count mid run");

    // R12: lookup with refill in the same cycle is dropped
    @(negedge clk);
    lookupValid = 1'b1; lookupVpn = 20'h10005;
    refillValid = 1'b1; refillVpn = 20'h40000; refillPfn = pfnOf(20'h40000);
    @(negedge clk);
    lookupValid = 1'b0; refillValid = 1'b0;
    hVpn = 20'h40000; hValid = 1'b1;
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R12 dropped lookup", sbq.size(), 0);
    doLookup(20'h40000, 1'b1, "R12 refill taken");
    doLookup(20'h10005, 1'b0, "R7 oldest evicted by refill");

    // R10: flush
    doFlush();
    doLookup(20'h30000, 1'b0, "R10 page gone after flush");
    doLookup(20'h10000, 1'b0, "R10 page gone after flush");
    doRefill(20'h50000);
    doLookup(20'h50000, 1'b1, "R6 R9 refill after flush");
    doLookup(20'h40000, 1'b0, "R10 no stale slot");
    chkCount("R11 final count");

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R3 R4 all responses seen", sbq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule